// File: doc/BRIEF.md
# Rotating Lane Bridge

This block carries a stream of valid-tagged events across a wire whose flight time is several clock cycles, without relay stations along the route. The wire is replaced by as many parallel lanes as the wire's delay in cycles. At the producer end, a splitter writes each cycle's event onto one lane, chosen by a rotation counter. Every other lane carries an empty slot in that cycle. Each lane is a chain of registers as long as the wire delay. At the consumer end, a merger reads the lanes back with its own rotation counter in the same lane order, so the single output stream is the input stream shifted by exactly the wire delay.

An empty input cycle (valid low) still uses its lane slot and comes out as an empty output cycle. The cycle-by-cycle pattern of the stream is therefore kept, not only the order of the valid events. The merger's counter stays parked until the first slot launched after reset reaches the far end, and it rotates every cycle from then on. This keeps the two ends in phase for any lane count.

The block has no back-pressure. It behaves like a wire: the producer may present an event every cycle, and the consumer must take every output cycle as it appears. Any ready/stall handling belongs to the shells on either side.

Top module: `rotating_lane_bridge`

## Requirements
- R1: With LANES set to the wire delay in cycles, out_valid and out_data in cycle t+LANES equal in_valid and in_data of cycle t (the data is copied only when valid is high).
- R2: An empty slot is carried with zero data: whenever out_valid is 0, out_data is 0. An inactive lane never carries a valid event.
- R3: The splitter's lane index is 0 in the first cycle after reset. It advances by one each cycle and wraps from LANES-1 back to 0, so exactly one lane carries the slot each cycle.
- R4: The merger's lane index stays at 0 until the first slot launched after reset arrives on lane 0. From that cycle on it advances by one each cycle with the same wrap, and the lane it reads always holds the arriving slot.
- R5: Empty input cycles keep their place: an input cycle with in_valid 0 yields an output cycle with out_valid 0 exactly LANES cycles later, between the neighbouring events.
- R6: During the first LANES cycles after reset is released, out_valid is 0.
- R7: While rst_n is low (asynchronous, active low), out_valid is 0 and out_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Event present this cycle at the producer end |
| in_data | input | DATA_W | Event payload at the producer end |
| out_valid | output | 1 | Event present this cycle at the consumer end |
| out_data | output | DATA_W | Event payload at the consumer end, zero when empty |

## Verification
The bench builds three copies side by side, with LANES set to 1, 3 and 4, all fed the same input stream.

LANES=1 is the degenerate case of a single lane with no rotation. LANES=3 makes the lane index wrap at a value that is not a power of two, so the index never reaches its all-ones code. LANES=4 wraps at the full counter width.

A mid-run reset, runs of empty cycles, an alternating pattern and random streams show whether either rotation counter slips out of phase at any of those wrap points.

// File: rtl/lane_bridge_pkg.sv
package lane_bridge_pkg;

  // Width of a lane index; a single lane still gets a one-bit index.
  function automatic int idx_width(input int lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction

endpackage

// File: rtl/lane_splitter.sv
module lane_splitter
  import lane_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  input  logic [DATA_W-1:0]              in_data,
  output logic [LANES-1:0]               lane_slot,
  output logic [LANES-1:0]               lane_vld,
  output logic [LANES-1:0][DATA_W-1:0]   lane_data
);
  localparam int IDX_W = idx_width(LANES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      lane_slot[l] = (cnt_q == IDX_W'(l));
      lane_vld[l]  = lane_slot[l] & in_valid;
      lane_data[l] = (lane_slot[l] && in_valid) ? in_data : '0;
    end
  end

  // R3: exactly one lane owns the slot every cycle
  p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(lane_slot));

  // R3: rotation wraps from the last lane to lane 0
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == LAST) |=> (cnt_q == '0));

  // R3: otherwise the index steps by one
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/lane_wire.sv
module lane_wire #(
  parameter int DATA_W = 16,
  parameter int LANES  = 3,
  parameter int DEPTH  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               src_slot,
  input  logic [LANES-1:0]               src_vld,
  input  logic [LANES-1:0][DATA_W-1:0]   src_data,
  output logic [LANES-1:0]               dst_slot,
  output logic [LANES-1:0]               dst_vld,
  output logic [LANES-1:0][DATA_W-1:0]   dst_data
);
  localparam int STAGE_W = DATA_W + 2;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DEPTH-1:0][STAGE_W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '0;
      end else begin
        pipe_q[0] <= {src_slot[l], src_vld[l], src_data[l]};
        for (int s = 1; s < DEPTH; s++) pipe_q[s] <= pipe_q[s-1];
      end
    end

    assign dst_slot[l] = pipe_q[DEPTH-1][STAGE_W-1];
    assign dst_vld[l]  = pipe_q[DEPTH-1][STAGE_W-2];
    assign dst_data[l] = pipe_q[DEPTH-1][DATA_W-1:0];

    // R2: a lane without the slot arrives empty with zero data
    p_idle_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !dst_slot[l] |-> (!dst_vld[l] && dst_data[l] == '0));
  end

endmodule

// File: rtl/lane_merger.sv
module lane_merger
  import lane_bridge_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LANES  = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [LANES-1:0]               lane_slot,
  input  logic [LANES-1:0]               lane_vld,
  input  logic [LANES-1:0][DATA_W-1:0]   lane_data,
  output logic                           out_valid,
  output logic [DATA_W-1:0]              out_data
);
  localparam int IDX_W = idx_width(LANES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] cnt_q;
  logic             started_q;
  logic             arrive;
  logic             advance;

  assign arrive  = lane_slot[0] & ~started_q;
  assign advance = started_q | arrive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else if (advance) begin
      started_q <= 1'b1;
      cnt_q     <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    out_valid = advance & lane_vld[cnt_q];
    out_data  = out_valid ? lane_data[cnt_q] : '0;
  end

  // R4: once rotating, the selected lane always holds the arriving slot
  p_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> lane_slot[cnt_q]);

  // R4: the index stays parked before the first slot arrives
  p_parked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !started_q |-> (cnt_q == '0));

  // R6: no output before the first slot arrives
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |-> !out_valid);

endmodule

// File: rtl/rotating_lane_bridge.sv
module rotating_lane_bridge #(
  parameter int DATA_W = 16,
  parameter int LANES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  logic [LANES-1:0]             near_slot, far_slot;
  logic [LANES-1:0]             near_vld,  far_vld;
  logic [LANES-1:0][DATA_W-1:0] near_data, far_data;

  lane_splitter #(.DATA_W(DATA_W), .LANES(LANES)) u_split (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .lane_slot(near_slot), .lane_vld(near_vld), .lane_data(near_data)
  );

  lane_wire #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(LANES)) u_wire (
    .clk(clk), .rst_n(rst_n),
    .src_slot(near_slot), .src_vld(near_vld), .src_data(near_data),
    .dst_slot(far_slot),  .dst_vld(far_vld),  .dst_data(far_data)
  );

  lane_merger #(.DATA_W(DATA_W), .LANES(LANES)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .lane_slot(far_slot), .lane_vld(far_vld), .lane_data(far_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R2: an empty output cycle carries zero data
  p_empty_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_data == '0));

endmodule

// File: tb/rotating_lane_bridge_bench.sv
module rotating_lane_bridge_bench;
  localparam int DW   = 16;
  localparam int HMAX = 4096;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [DW-1:0] in_data;
  logic          ov1, ov3, ov4;
  logic [DW-1:0] od1, od3, od4;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 0;

  logic          hist_v [HMAX];
  logic [DW-1:0] hist_d [HMAX];

  always #2.5 clk = ~clk;

  rotating_lane_bridge #(.DATA_W(DW), .LANES(3)) u_rotating_lane_bridge (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov3), .out_data(od3));

  rotating_lane_bridge #(.DATA_W(DW), .LANES(1)) u_rotating_lane_bridge_n1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov1), .out_data(od1));

  rotating_lane_bridge #(.DATA_W(DW), .LANES(4)) u_rotating_lane_bridge_n4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov4), .out_data(od4));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Reference: output equals the input of cycle (cyc - n), empty before that.
  task automatic check_one(input int n, input logic v, input logic [DW-1:0] d);
    logic          ev;
    logic [DW-1:0] ed;
    if (cyc < n) begin
      ev = 1'b0; ed = '0;
    end else begin
      ev = hist_v[cyc-n];
      ed = ev ? hist_d[cyc-n] : '0;
    end
    checks++;
    if (v !== ev) begin
      errors++;
      if (cyc < n)
        $display("FAIL R6 lanes=%0d cyc=%0d out_valid=%0b expected=%0b", n, cyc, v, ev);
      else
        $display("FAIL R1/R3/R4/R5 lanes=%0d cyc=%0d out_valid=%0b expected=%0b", n, cyc, v, ev);
    end
    checks++;
    if (d !== ed) begin
      errors++;
      if (!ev)
        $display("FAIL R2 lanes=%0d cyc=%0d out_data=%h expected=%h", n, cyc, d, ed);
      else
        $display("FAIL R1/R3/R4 lanes=%0d cyc=%0d out_data=%h expected=%h", n, cyc, d, ed);
    end
  endtask

  task automatic check_reset_state();
    checks++;
    if (ov1 !== 1'b0 || ov3 !== 1'b0 || ov4 !== 1'b0 ||
        od1 !== '0 || od3 !== '0 || od4 !== '0) begin
      errors++;
      $display("FAIL R7 out_valid=%0b%0b%0b out_data=%h/%h/%h expected=0 and 0",
               ov1, ov3, ov4, od1, od3, od4);
    end
  endtask

  // Called at a falling edge: compare, then drive and record this cycle's input.
  task automatic step(input logic v, input logic [DW-1:0] d);
    check_one(1, ov1, od1);
    check_one(3, ov3, od3);
    check_one(4, ov4, od4);
    in_valid = v;
    in_data  = d;
    hist_v[cyc] = v;
    hist_d[cyc] = d;
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    cyc   = 0;
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    @(negedge clk);
    do_reset();
    // R3/R4: dense stream exposes every lane rotation and wrap
    for (int i = 0; i < 40; i++) step(1'b1, DW'(i + 1));
    // R5: random gaps between events
    for (int i = 0; i < 80; i++) step(1'($urandom % 2), DW'($urandom));
    // R5/R2: long empty run, then a burst
    for (int i = 0; i < 20; i++) step(1'b0, DW'($urandom));
    for (int i = 0; i < 10; i++) step(1'b1, DW'(16'hA000 + i));
    // R5: alternating pattern, phase against odd and even lane counts
    for (int i = 0; i < 30; i++) step(1'(i % 2), DW'(16'h5000 + i));
    // R7/R6: reset in the middle of traffic, then restart
    do_reset();
    for (int i = 0; i < 60; i++) step(1'($urandom % 4 != 0), DW'($urandom));
    for (int i = 0; i < 10; i++) step(1'b0, '0);
    finish_run();
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog expired at cyc=%0d expected completion", cyc);
    finish_run();
  end

endmodule